// File: doc/BRIEF.md
# Systolic Evolvable Window Filter Array

This block is a rectangular mesh of small pipelined processing cells used as a gene-configured image filter. Every clock cycle a 3×3 neighbourhood of 8-bit pixels arrives on one flat input. Each cell in the top row takes its north operand from the window through its own 4-bit select gene. Each cell in the left column takes its west operand from the window the same way. Inside the mesh, a cell's west operand is the registered result of the cell to its left, and its north operand is the registered result of the cell above it.

Each cell applies one of sixteen pixel operations, chosen by its own 4-bit function gene, and registers the result. The filtered pixel is the register of the lower-right cell. An external search engine writes a whole candidate circuit as one flat chromosome vector, streams windows through the mesh and scores the output. A delayed copy of the input strobe marks the output cycles that belong to the current stream.

Top module: `evo_filter_array`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `pix_out` is 0 and `pix_out_valid` is 0. Reset is synchronous and active high.
- R2: Cell (column c, row r) has a west operand equal to the registered result of cell (c-1, r) and a north operand equal to the registered result of cell (c, r-1). Each cell's result is registered once per clock, and `pix_out` is the register of cell (COLS-1, ROWS-1).
- R3: Window pixel p sits at bits [8p+7:8p] of `win_pix`, and pixels are numbered 0 to 8 in row-major order. A border select gene value s from 0 to 8 routes pixel s, and any value from 9 to 15 routes pixel 0.
- R4: Function codes 0 to 7, with N the north operand and W the west operand: 0 gives 255, 1 gives N, 2 gives W, 3 gives N>>1, 4 gives W>>1, 5 gives (N+W) mod 256, 6 gives (2N) mod 256, and 7 gives (2W) mod 256.
- R5: Function codes 8 to 15: 8 gives min(N+W,255), 9 gives min(2N,255), 10 gives min(2W,255), 11 gives floor((N+W)/2) computed without overflow, 12 gives max(N,W), 13 gives min(N,W), 14 gives N-W or 0 if N<W, and 15 gives W-N or 0 if W<N.
- R6: Gene g occupies bits [4g+3:4g] of `genes`. Genes 0 to COLS-1 select the north operand of top-row column g. Genes COLS to COLS+ROWS-1 select the west operand of left-column row g-COLS. Gene COLS+ROWS+r*COLS+c is the function of cell (c, r).
- R7: `pix_out_valid` equals `win_valid` delayed by LAT clock edges, with LAT defaulting to COLS+ROWS-1. With the default value, the first flagged output is the first output that reflects the flagged window in the lower-right cell.
- R8: A new window is accepted on every clock edge, with no stall. When the input stream changes every cycle, the output sequence matches the cycle-by-cycle mesh behaviour of R2 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_pix | input | 72 | Nine 8-bit window pixels, row-major |
| win_valid | input | 1 | Marks the window on `win_pix` as part of the stream |
| genes | input | 4*(COLS+ROWS+COLS*ROWS) | Flat chromosome of select and function genes |
| pix_out | output | 8 | Registered result of the lower-right cell |
| pix_out_valid | output | 1 | Delayed input strobe |

## Verification
The first pattern holds a window constant while a pass-west chain feeds the corner. Sweeping every select value in it separates correct pixel routing from the fallback of codes 9 to 15. In the second pattern, a column of pass-north cells and a row of pass-west cells deliver two chosen pixels to the corner cell. Each of the sixteen codes is then tried with one operand pair where north is larger and the sum overflows, and a second pair where west is larger, so wrap, saturation and clamp to zero are told apart. Finally, random chromosomes are run with a window that changes every cycle against a cycle-level mesh model. This exposes wrong link directions, wrong gene positions, extra or missing pipeline stages and a misaligned valid flag.

// File: rtl/evo_pkg.sv
package evo_pkg;

    localparam int PIX_W  = 8;
    localparam int WIN_N  = 9;
    localparam int GENE_W = 4;

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [GENE_W-1:0] {
        OP_ONES      = 4'd0,
        OP_N         = 4'd1,
        OP_W         = 4'd2,
        OP_N_HALF    = 4'd3,
        OP_W_HALF    = 4'd4,
        OP_ADD_WRAP  = 4'd5,
        OP_N_DBL     = 4'd6,
        OP_W_DBL     = 4'd7,
        OP_ADD_SAT   = 4'd8,
        OP_N_DBL_SAT = 4'd9,
        OP_W_DBL_SAT = 4'd10,
        OP_MEAN      = 4'd11,
        OP_MAX       = 4'd12,
        OP_MIN       = 4'd13,
        OP_N_SUB_W   = 4'd14,
        OP_W_SUB_N   = 4'd15
    } op_e;

    function automatic pix_t clamp_sum(input logic [PIX_W:0] s);
        return s[PIX_W] ? '1 : s[PIX_W-1:0];
    endfunction

    function automatic pix_t floor_diff(input pix_t a, input pix_t b);
        return (a > b) ? pix_t'(a - b) : '0;
    endfunction

    function automatic pix_t pe_eval(input op_e op, input pix_t n, input pix_t w);
        logic [PIX_W:0] s_nw;
        logic [PIX_W:0] s_nn;
        logic [PIX_W:0] s_ww;
        pix_t r;
        s_nw = {1'b0, n} + {1'b0, w};
        s_nn = {n, 1'b0};
        s_ww = {w, 1'b0};
        case (op)
            OP_ONES:      r = '1;
            OP_N:         r = n;
            OP_W:         r = w;
            OP_N_HALF:    r = n >> 1;
            OP_W_HALF:    r = w >> 1;
            OP_ADD_WRAP:  r = s_nw[PIX_W-1:0];
            OP_N_DBL:     r = s_nn[PIX_W-1:0];
            OP_W_DBL:     r = s_ww[PIX_W-1:0];
            OP_ADD_SAT:   r = clamp_sum(s_nw);
            OP_N_DBL_SAT: r = clamp_sum(s_nn);
            OP_W_DBL_SAT: r = clamp_sum(s_ww);
            OP_MEAN:      r = s_nw[PIX_W:1];
            OP_MAX:       r = (n > w) ? n : w;
            OP_MIN:       r = (n < w) ? n : w;
            OP_N_SUB_W:   r = floor_diff(n, w);
            OP_W_SUB_N:   r = floor_diff(w, n);
            default:      r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/evo_window_mux.sv
module evo_window_mux
    import evo_pkg::*;
(
    input  logic [WIN_N*PIX_W-1:0] win,
    input  logic [GENE_W-1:0]      sel,
    output pix_t                   pix
);
    always_comb begin
        if (sel < GENE_W'(WIN_N)) begin
            pix = win[{sel, 3'b000} +: PIX_W];
        end else begin
            pix = win[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/evo_pe.sv
module evo_pe
    import evo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    input  pix_t n_in,
    input  pix_t w_in,
    output pix_t z_out
);
    pix_t z_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            z_q <= '0;
        end else begin
            z_q <= pe_eval(op, n_in, w_in);
        end
    end

    assign z_out = z_q;

    AST_SAT_SUM_CEIL: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADD_SAT) |=> (z_q >= $past(n_in) && z_q >= $past(w_in))); // R5

    AST_MAX_DOMINATES: assert property (@(posedge clk) disable iff (rst)
        (op == OP_MAX) |=> (z_q >= $past(n_in) && z_q >= $past(w_in))); // R5

    AST_MIN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (op == OP_MIN) |=> (z_q <= $past(n_in) && z_q <= $past(w_in))); // R5

    AST_HALF_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (op == OP_N_HALF || op == OP_W_HALF) |=> (z_q[PIX_W-1] == 1'b0)); // R4
endmodule

// File: rtl/evo_valid_delay.sv
module evo_valid_delay #(
    parameter int DEPTH = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [DEPTH-1:0] sr;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= d_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[DEPTH-2:0], d_in};
            end
        end
    endgenerate

    assign d_out = sr[DEPTH-1];
endmodule

// File: rtl/evo_filter_array.sv
module evo_filter_array
    import evo_pkg::*;
#(
    parameter int COLS = 6,
    parameter int ROWS = 6,
    parameter int LAT  = COLS + ROWS - 1
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic [WIN_N*PIX_W-1:0]                  win_pix,
    input  logic                                    win_valid,
    input  logic [GENE_W*(COLS+ROWS+COLS*ROWS)-1:0] genes,
    output logic [PIX_W-1:0]                        pix_out,
    output logic                                    pix_out_valid
);
    localparam int SEL_BASE_W = COLS;
    localparam int FUNC_BASE  = COLS + ROWS;

    pix_t top_pix  [COLS];
    pix_t left_pix [ROWS];
    pix_t z        [COLS][ROWS];

    genvar c, r;
    generate
        for (c = 0; c < COLS; c++) begin : g_top_mux
            evo_window_mux u_mux (
                .win (win_pix),
                .sel (genes[GENE_W*c +: GENE_W]),
                .pix (top_pix[c])
            );
        end
        for (r = 0; r < ROWS; r++) begin : g_left_mux
            evo_window_mux u_mux (
                .win (win_pix),
                .sel (genes[GENE_W*(SEL_BASE_W+r) +: GENE_W]),
                .pix (left_pix[r])
            );
        end
        for (c = 0; c < COLS; c++) begin : g_col
            for (r = 0; r < ROWS; r++) begin : g_row
                pix_t n_op;
                pix_t w_op;
                if (r == 0) begin : g_n_border
                    assign n_op = top_pix[c];
                end else begin : g_n_mesh
                    assign n_op = z[c][r-1];
                end
                if (c == 0) begin : g_w_border
                    assign w_op = left_pix[r];
                end else begin : g_w_mesh
                    assign w_op = z[c-1][r];
                end
                evo_pe u_pe (
                    .clk   (clk),
                    .rst   (rst),
                    .op    (op_e'(genes[GENE_W*(FUNC_BASE+r*COLS+c) +: GENE_W])),
                    .n_in  (n_op),
                    .w_in  (w_op),
                    .z_out (z[c][r])
                );
            end
        end
    endgenerate

    evo_valid_delay #(.DEPTH(LAT)) u_vdly (
        .clk   (clk),
        .rst   (rst),
        .d_in  (win_valid),
        .d_out (pix_out_valid)
    );

    assign pix_out = z[COLS-1][ROWS-1];

    AST_VALID_LOW_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pix_out_valid); // R1

    AST_PIXEL_ZERO_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pix_out == '0)); // R1
endmodule

// File: tb/evo_filter_array_bench.sv
`timescale 1ns/1ps
module evo_filter_array_bench;
    localparam int COLS = 6;
    localparam int ROWS = 6;
    localparam int LAT  = COLS + ROWS - 1;
    localparam int NG   = COLS + ROWS + COLS*ROWS;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [71:0]      win = '0;
    logic             in_valid = 1'b0;
    logic [4*NG-1:0]  cfg = '0;
    logic [7:0]       pix_out;
    logic             pix_out_valid;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit exp_v  = 1'b0;
    int sb[$];

    int mz [COLS][ROWS];
    int nz [COLS][ROWS];
    bit [LAT-1:0] mv = '0;

    always #2 clk = ~clk;

    evo_filter_array #(.COLS(COLS), .ROWS(ROWS)) u_evo_filter_array (
        .clk           (clk),
        .rst           (rst),
        .win_pix       (win),
        .win_valid     (in_valid),
        .genes         (cfg),
        .pix_out       (pix_out),
        .pix_out_valid (pix_out_valid)
    );

    // Operation table written from R4 and R5
    function automatic int ref_op(input int code, input int n, input int w);
        case (code)
            0:  return 255;
            1:  return n;
            2:  return w;
            3:  return n / 2;
            4:  return w / 2;
            5:  return (n + w) % 256;
            6:  return (2 * n) % 256;
            7:  return (2 * w) % 256;
            8:  return (n + w > 255) ? 255 : n + w;
            9:  return (2 * n > 255) ? 255 : 2 * n;
            10: return (2 * w > 255) ? 255 : 2 * w;
            11: return (n + w) / 2;
            12: return (n > w) ? n : w;
            13: return (n < w) ? n : w;
            14: return (n > w) ? n - w : 0;
            default: return (w > n) ? w - n : 0;
        endcase
    endfunction

    function automatic int gene(input int g);
        return int'(cfg[4*g +: 4]);
    endfunction

    function automatic int wpix(input int sel);
        int p;
        p = (sel <= 8) ? sel : 0; // R3
        return int'(win[8*p +: 8]);
    endfunction

    task automatic set_gene(input int g, input int v);
        cfg[4*g +: 4] = 4'(v);
    endtask

    task automatic set_op(input int c, input int r, input int v);
        set_gene(COLS + ROWS + r*COLS + c, v); // R6
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: applies one window, steps the model, queues the expected item
    task automatic drive(input logic [71:0] w, input bit v);
        @(negedge clk);
        win = w;
        in_valid = v;
        for (int c = 0; c < COLS; c++) begin
            for (int r = 0; r < ROWS; r++) begin
                int n_op;
                int w_op;
                n_op = (r == 0) ? wpix(gene(c)) : mz[c][r-1];
                w_op = (c == 0) ? wpix(gene(COLS + r)) : mz[c-1][r];
                nz[c][r] = ref_op(gene(COLS + ROWS + r*COLS + c), n_op, w_op);
            end
        end
        @(posedge clk);
        #1;
        mz = nz;
        mv = {mv[LAT-2:0], v};
        exp_v = mv[LAT-1];
        if (exp_v) sb.push_back(mz[COLS-1][ROWS-1]);
    endtask

    // Monitor: compares flag and pixel against the scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (pix_out_valid !== exp_v) begin
                checks++;
                errors++;
                $display("FAIL R7 valid actual %0b expected %0b", pix_out_valid, exp_v);
                sb.delete();
            end else if (pix_out_valid) begin
                if (sb.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R8 output actual %0d expected none", pix_out);
                end else begin
                    int e;
                    e = sb.pop_front();
                    check("R8 R2 stream", int'(pix_out), e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [71:0] w;
        for (int c = 0; c < COLS; c++)
            for (int r = 0; r < ROWS; r++) mz[c][r] = 0;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 pixel", int'(pix_out), 0);
        check("R1 valid", int'(pix_out_valid), 0);
        rst = 1'b0;
        mon_on = 1'b1;

        // R3: select sweep through a pass-west chain on the bottom row
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) set_op(c, r, 2);
        for (int p = 0; p < 9; p++) w[8*p +: 8] = 8'(10 + 23*p);
        for (int s = 0; s < 16; s++) begin
            set_gene(COLS + ROWS - 1, s);
            repeat (COLS + 3) drive(w, 1'b1);
            check("R3 select", int'(pix_out), (s <= 8) ? 10 + 23*s : 10);
        end

        // R4 R5: each code in the corner, operands delivered by chains
        cfg = '0;
        for (int r = 0; r < ROWS - 1; r++) set_op(COLS-1, r, 1);
        for (int c = 0; c < COLS - 1; c++) set_op(c, ROWS-1, 2);
        set_gene(COLS-1, 3);
        set_gene(COLS + ROWS - 1, 7);
        for (int k = 0; k < 2; k++) begin
            int xn;
            int yw;
            xn = (k == 0) ? 200 : 40;
            yw = (k == 0) ? 100 : 250;
            w = '0;
            w[8*3 +: 8] = 8'(xn);
            w[8*7 +: 8] = 8'(yw);
            for (int code = 0; code < 16; code++) begin
                set_op(COLS-1, ROWS-1, code);
                repeat (COLS + ROWS + 1) drive(w, 1'b1);
                check((code < 8) ? "R4 op" : "R5 op", int'(pix_out), ref_op(code, xn, yw));
            end
        end

        // R7: valid follows the strobe with a gap
        repeat (LAT + 2) drive(w, 1'b0);
        check("R7 valid idle", int'(pix_out_valid), 0);

        // R8 R2 R6: random chromosomes with windows changing every cycle
        for (int t = 0; t < 8; t++) begin
            for (int g = 0; g < NG; g++) set_gene(g, int'($urandom_range(0, 15)));
            for (int i = 0; i < 50; i++) begin
                for (int p = 0; p < 9; p++) w[8*p +: 8] = 8'($urandom_range(0, 255));
                drive(w, (i % 7) != 3);
            end
        end
        repeat (LAT + 2) drive(w, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule